// File: doc/BRIEF.md
# Parallel ADC Conversion Controller

This block runs a 16-bit analog-to-digital converter that has a parallel result bus. The host side pulses `start_i`. The controller then drives the converter's active-low chip-select, read/convert and byte-select lines to begin a conversion. It follows the converter's active-low busy line through a low phase and back high, and then reads the result.

The converter combines its two strobes with an OR, so the meaning of an edge on one line depends on the level of the other. The controller supports two strobing schemes:

- **Default scheme:** chip-select rests low and read/convert pulses low to convert.
- **Alternative scheme:** chip-select is the active strobe. Read/convert is held low while a conversion starts and high while the result is read.

The result comes back either as one 16-bit word or as two 8-bit reads on the low pin group. For the byte reads, the byte-select line swaps the halves of the bus between the two reads.

Busy and the data pins both pass through a two-flop synchronizer. Every read phase holds for a programmable settle count before the bus is sampled. The assembled word is presented with a one-cycle valid strobe. If busy does not complete its low/high sequence within a programmable cycle limit, a one-cycle error strobe is raised instead.

Top module: `adc_conv_ctrl`

## Requirements
- R1: When idle in the default scheme (`cs_mode_i`=0), `cs_n_o`=0 and `rc_o`=1. When idle in the alternative scheme (`cs_mode_i`=1), `cs_n_o`=1 and `rc_o`=0. `byte_sel_o`=0 in both schemes.
- R2: An accepted start in the default scheme holds `rc_o` low for `settle_i`+1 cycles while `cs_n_o` stays low. Every accepted start produces exactly one conversion-start edge at the converter.
- R3: An accepted start in the alternative scheme drives `cs_n_o` low with `rc_o` low. For the read, `rc_o` is raised while `cs_n_o` is high, and only then does `cs_n_o` fall.
- R4: After the start, the controller waits for synchronized busy to go low and then high. It samples the data pins only while `cs_n_o`=0 and `rc_o`=1, and it never reports a result before busy has risen.
- R5: In word mode (`byte_mode_i`=0), the result equals `data_i[15:0]`, read with `byte_sel_o`=0 after the settle count plus two synchronizer cycles.
- R6: In byte mode (`byte_mode_i`=1), `data_i[7:0]` is read twice. The first read, with `byte_sel_o`=0, gives result bits 7..0. The second read, with `byte_sel_o`=1 (the converter then puts bits 15..8 on the low pins), gives result bits 15..8. `byte_sel_o` is high only while `cs_n_o`=0 and `rc_o`=1.
- R7: `valid_o` is high for exactly one cycle per completed conversion, together with the new `result_o`. `result_o` holds its value at all other times.
- R8: A start request is ignored while a conversion or read is in progress, and also while synchronized busy is low.
- R9: If busy has not gone low and then high within `tmo_limit_i` cycles of waiting, `timeout_o` pulses for one cycle, no `valid_o` is given, and the controller returns to idle.
- R10: After reset, `valid_o`=0, `timeout_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request |
| cs_mode_i | input | 1 | 0: read/convert strobes; 1: chip-select strobes |
| byte_mode_i | input | 1 | 0: one 16-bit read; 1: two 8-bit reads |
| settle_i | input | SETTLE_W | Extra hold cycles for each strobe and read phase |
| tmo_limit_i | input | TMO_W | Busy wait limit in cycles |
| busy_n_i | input | 1 | Converter busy, low while converting |
| data_i | input | DATA_W | Converter data pins |
| cs_n_o | output | 1 | Chip-select, active low |
| rc_o | output | 1 | Read/convert line |
| byte_sel_o | output | 1 | Byte-swap select |
| result_o | output | DATA_W | Last assembled result |
| valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | One-cycle busy timeout strobe |

## Verification
The hardest case to reach from the ports is a converter whose busy line never rises. After the resulting timeout, the controller is idle while busy is still low, and a start request at that point must be rejected. The bench's converter model has a hang switch that freezes its busy line low. With the switch set, the bench waits for the timeout strobe, then pulses start and counts the conversion edges that reach the model. Only after that does it release the model. Random transactions also pulse start in the middle of a conversion, so rejection during an active read is covered as well.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    // Flops between a converter pin and the sequencer
    localparam int SYNC_LAT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_READ_LO,
        ST_READ_HI
    } seq_state_e;
endpackage

// File: rtl/adc_sync_stage.sv
module adc_sync_stage #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = din_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.s1 <= RST_VAL;
            sync_q.s2 <= RST_VAL;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout_o = sync_q.s2;
endmodule

// File: rtl/adc_watch_timer.sv
module adc_watch_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cs_mode_i,
    input  logic                byte_mode_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                busy_s_i,
    input  logic [DATA_W-1:0]   data_s_i,
    input  logic                tmo_expired_i,
    output logic                tmo_run_o,
    output logic                tmo_clear_o,
    output logic                cs_n_o,
    output logic                rc_o,
    output logic                byte_sel_o,
    output logic [DATA_W-1:0]   result_o,
    output logic                valid_o,
    output logic                timeout_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int CW     = SETTLE_W + 2;

    typedef struct packed {
        seq_state_e          st;
        logic                cs_mode;
        logic                byte_mode;
        logic [SETTLE_W-1:0] settle;
        logic [CW-1:0]       cnt;
        logic [HALF_W-1:0]   lo_byte;
        logic [DATA_W-1:0]   result;
        logic                valid;
        logic                timeout;
    } seq_t;

    seq_t seq_d, seq_q;

    logic conv_done;
    logic read_done;
    logic waiting;
    logic mode_now;

    assign conv_done = (seq_q.cnt == CW'(seq_q.settle));
    assign read_done = (seq_q.cnt == (CW'(seq_q.settle) + CW'(SYNC_LAT)));
    assign waiting   = (seq_q.st == ST_WAIT_LO) || (seq_q.st == ST_WAIT_HI);

    always_comb begin
        seq_d         = seq_q;
        seq_d.valid   = 1'b0;
        seq_d.timeout = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i && busy_s_i) begin
                    seq_d.st        = ST_CONV;
                    seq_d.cs_mode   = cs_mode_i;
                    seq_d.byte_mode = byte_mode_i;
                    seq_d.settle    = settle_i;
                    seq_d.cnt       = '0;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    seq_d.st  = ST_WAIT_LO;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_WAIT_LO: begin
                if (tmo_expired_i) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.timeout = 1'b1;
                end else if (!busy_s_i) begin
                    seq_d.st = ST_WAIT_HI;
                end
            end
            ST_WAIT_HI: begin
                if (tmo_expired_i) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.timeout = 1'b1;
                end else if (busy_s_i) begin
                    seq_d.st  = ST_READ_LO;
                    seq_d.cnt = '0;
                end
            end
            ST_READ_LO: begin
                if (read_done) begin
                    if (seq_q.byte_mode) begin
                        seq_d.lo_byte = data_s_i[HALF_W-1:0];
                        seq_d.st      = ST_READ_HI;
                        seq_d.cnt     = '0;
                    end else begin
                        seq_d.result = data_s_i;
                        seq_d.valid  = 1'b1;
                        seq_d.st     = ST_IDLE;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_READ_HI: begin
                if (read_done) begin
                    seq_d.result = {data_s_i[HALF_W-1:0], seq_q.lo_byte};
                    seq_d.valid  = 1'b1;
                    seq_d.st     = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st        <= ST_IDLE;
            seq_q.cs_mode   <= 1'b0;
            seq_q.byte_mode <= 1'b0;
            seq_q.settle    <= '0;
            seq_q.cnt       <= '0;
            seq_q.lo_byte   <= '0;
            seq_q.result    <= '0;
            seq_q.valid     <= 1'b0;
            seq_q.timeout   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Pin levels decoded from the registered phase
    assign mode_now = (seq_q.st == ST_IDLE) ? cs_mode_i : seq_q.cs_mode;

    always_comb begin
        cs_n_o     = 1'b0;
        rc_o       = 1'b1;
        byte_sel_o = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                cs_n_o = mode_now;
                rc_o   = !mode_now;
            end
            ST_CONV: begin
                cs_n_o = 1'b0;
                rc_o   = 1'b0;
            end
            ST_WAIT_LO, ST_WAIT_HI: begin
                cs_n_o = mode_now;
                rc_o   = 1'b1;
            end
            ST_READ_LO: begin
                cs_n_o = 1'b0;
                rc_o   = 1'b1;
            end
            ST_READ_HI: begin
                cs_n_o     = 1'b0;
                rc_o       = 1'b1;
                byte_sel_o = 1'b1;
            end
            default: begin
                cs_n_o = 1'b1;
                rc_o   = 1'b1;
            end
        endcase
    end

    assign tmo_run_o   = waiting;
    assign tmo_clear_o = !waiting;
    assign result_o    = seq_q.result;
    assign valid_o     = seq_q.valid;
    assign timeout_o   = seq_q.timeout;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
    parameter int DATA_W   = 16,
    parameter int SETTLE_W = 4,
    parameter int TMO_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cs_mode_i,
    input  logic                byte_mode_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [TMO_W-1:0]    tmo_limit_i,
    input  logic                busy_n_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic                cs_n_o,
    output logic                rc_o,
    output logic                byte_sel_o,
    output logic [DATA_W-1:0]   result_o,
    output logic                valid_o,
    output logic                timeout_o
);
    logic              busy_s;
    logic [DATA_W-1:0] data_s;
    logic              tmo_run;
    logic              tmo_clear;
    logic              tmo_expired;

    adc_sync_stage #(.W(1), .RST_VAL(1'b1)) u_busy_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (busy_n_i),
        .dout_o (busy_s)
    );

    adc_sync_stage #(.W(DATA_W), .RST_VAL('0)) u_data_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (data_i),
        .dout_o (data_s)
    );

    adc_watch_timer #(.CNT_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmo_run),
        .clear_i   (tmo_clear),
        .limit_i   (tmo_limit_i),
        .expired_o (tmo_expired)
    );

    adc_seq_fsm #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cs_mode_i     (cs_mode_i),
        .byte_mode_i   (byte_mode_i),
        .settle_i      (settle_i),
        .busy_s_i      (busy_s),
        .data_s_i      (data_s),
        .tmo_expired_i (tmo_expired),
        .tmo_run_o     (tmo_run),
        .tmo_clear_o   (tmo_clear),
        .cs_n_o        (cs_n_o),
        .rc_o          (rc_o),
        .byte_sel_o    (byte_sel_o),
        .result_o      (result_o),
        .valid_o       (valid_o),
        .timeout_o     (timeout_o)
    );
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_o,
    input logic              rc_o,
    input logic              byte_sel_o,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              timeout_o
);
    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |=> (valid_o || $stable(result_o)));

    // R6
    byte_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sel_o |-> (!cs_n_o && rc_o));

    // R4
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(!cs_n_o && rc_o));

    // R9
    timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !valid_o);

    // R9
    timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_o     (cs_n_o),
    .rc_o       (rc_o),
    .byte_sel_o (byte_sel_o),
    .result_o   (result_o),
    .valid_o    (valid_o),
    .timeout_o  (timeout_o)
);

// File: tb/adc_conv_ctrl_test.sv
module adc_conv_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cs_mode = 1'b0;
    logic        byte_mode = 1'b0;
    logic [3:0]  settle = 4'd0;
    logic [15:0] tmo_limit = 16'd100;
    logic        busy_n;
    logic [15:0] data_pins;
    logic        cs_n, rc, byte_sel, valid, timeout;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // converter model controls
    int          m_len = 5;
    logic [15:0] m_code = 16'h0;
    logic        m_hang = 1'b0;
    logic        m_busy_n;
    logic [15:0] m_out, m_hold;
    logic        prev_cs, prev_rc;
    int          m_timer;
    int          conv_count;
    int          rise_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_conv_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cs_mode_i   (cs_mode),
        .byte_mode_i (byte_mode),
        .settle_i    (settle),
        .tmo_limit_i (tmo_limit),
        .busy_n_i    (busy_n),
        .data_i      (data_pins),
        .cs_n_o      (cs_n),
        .rc_o        (rc),
        .byte_sel_o  (byte_sel),
        .result_o    (result),
        .valid_o     (valid),
        .timeout_o   (timeout)
    );

    function automatic logic [15:0] pins_of(logic [15:0] w, logic swap);
        return swap ? {w[7:0], w[15:8]} : w;
    endfunction

    function automatic logic [1:0] idle_levels(logic csm);
        return csm ? 2'b10 : 2'b01;  // {cs_n, rc}
    endfunction

    // Converter stand-in: OR-combined strobes, busy, output register
    assign busy_n    = m_busy_n;
    assign data_pins = (!cs_n && rc) ? pins_of(m_out, byte_sel) : 16'hA5C3;

    logic conv_edge;
    assign conv_edge = (prev_rc && !rc && !prev_cs && !cs_n) ||
                       (!prev_rc && !rc && prev_cs && !cs_n);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_busy_n   <= 1'b1;
            m_out      <= 16'h0;
            m_hold     <= 16'h0;
            prev_cs    <= 1'b1;
            prev_rc    <= 1'b1;
            m_timer    <= 0;
            conv_count <= 0;
            rise_cyc   <= 0;
        end else begin
            prev_cs <= cs_n;
            prev_rc <= rc;
            if (conv_edge && m_busy_n) begin
                m_busy_n   <= 1'b0;
                m_timer    <= m_len;
                m_hold     <= m_code;
                conv_count <= conv_count + 1;
            end else if (!m_busy_n && !m_hang) begin
                if (m_timer <= 1) begin
                    m_busy_n <= 1'b1;
                    m_out    <= m_hold;
                    rise_cyc <= cyc;
                end else begin
                    m_timer <= m_timer - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        logic [1:0] e;
        e = idle_levels(cs_mode);
        chk({cs_n, rc} == e && !byte_sel, req, "idle levels {cs_n,rc,bsel}",
            {29'd0, cs_n, rc, byte_sel}, {29'd0, e, 1'b0});
    endtask

    task automatic txn(input bit csm, input bit bm, input logic [3:0] st,
                       input int clen, input logic [15:0] code, input bit extra);
        int base, seen_v, seen_t, waited, vcyc, rc_low_run, max_rc_low;
        bit saw_bs;
        logic [15:0] got;
        @(negedge clk);
        cs_mode = csm; byte_mode = bm; settle = st;
        m_len = clen; m_code = code;
        @(negedge clk);
        check_idle(csm ? "R1/R3" : "R1");
        base = conv_count;
        seen_v = 0; seen_t = 0; waited = 0; vcyc = 0; saw_bs = 0; got = '0;
        rc_low_run = 0; max_rc_low = 0;
        start = 1'b1;
        while (waited < 3000 && seen_v == 0 && seen_t == 0) begin
            @(negedge clk);
            waited++;
            start = (extra && waited >= 6 && waited <= 8);
            if (byte_sel) saw_bs = 1;
            if (!rc && !cs_n) rc_low_run++; else rc_low_run = 0;
            if (rc_low_run > max_rc_low) max_rc_low = rc_low_run;
            if (timeout) seen_t++;
            if (valid) begin seen_v++; got = result; vcyc = cyc; end
        end
        start = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (valid) seen_v++;
            if (timeout) seen_t++;
        end
        // R5 / R6: assembled word equals the converter's code
        chk(got == code, bm ? "R6" : "R5", "result word", {16'd0, got}, {16'd0, code});
        // R7: exactly one valid cycle
        chk(seen_v == 1, "R7", "valid cycles", seen_v, 1);
        // R2 / R8: one conversion per accepted start, extra starts ignored
        chk(conv_count - base == 1, extra ? "R8" : (csm ? "R3" : "R2"),
            "conversion edges", conv_count - base, 1);
        // R9: no timeout on a healthy conversion
        chk(seen_t == 0, "R9", "spurious timeout", seen_t, 0);
        // R6: byte select used only in byte mode
        chk(saw_bs == bm, "R6", "byte select seen", {31'd0, saw_bs}, {31'd0, bm});
        // R4: result not reported before busy has risen and passed the synchronizer
        chk(vcyc > rise_cyc + 4, "R4", "valid after busy rise", vcyc, rise_cyc + 5);
        // R2: strobe width in the default scheme
        if (!csm)
            chk(max_rc_low == int'(st) + 1, "R2", "rc low width", max_rc_low, int'(st) + 1);
        check_idle("R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(!valid && !timeout && result == 16'h0, "R10", "reset outputs",
            {14'd0, valid, timeout, result}, 32'd0);
        check_idle("R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // directed corners: extreme codes, both schemes, both read widths
        txn(1'b0, 1'b0, 4'd0, 3,  16'h7FFF, 1'b0);
        txn(1'b0, 1'b1, 4'd2, 6,  16'h8000, 1'b0);
        txn(1'b1, 1'b0, 4'd1, 4,  16'h0000, 1'b0);
        txn(1'b1, 1'b1, 4'd0, 3,  16'hFFFF, 1'b0);
        txn(1'b0, 1'b1, 4'd15, 20, 16'h12F0, 1'b1);
        txn(1'b1, 1'b1, 4'd3, 10, 16'h00FF, 1'b1);

        // R9 / R8: converter hangs with busy low
        for (int k = 0; k < 2; k++) begin
            int base, seen_t, seen_v;
            @(negedge clk);
            cs_mode = k[0]; byte_mode = 1'b0; settle = 4'd1;
            tmo_limit = 16'd30; m_hang = 1'b1; m_len = 4; m_code = 16'h4321;
            base = conv_count; seen_t = 0; seen_v = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (timeout) seen_t++;
                if (valid) seen_v++;
            end
            chk(seen_t == 1, "R9", "timeout strobes", seen_t, 1);
            chk(seen_v == 0, "R9", "valid after timeout", seen_v, 0);
            check_idle("R9");
            // start while busy still low must be ignored
            start = 1'b1;
            repeat (3) @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            chk(conv_count - base == 1, "R8", "start with busy low", conv_count - base, 1);
            check_idle("R8");
            m_hang = 1'b0;
            repeat (20) @(negedge clk);
            tmo_limit = 16'd100;
        end

        // constrained random
        for (int n = 0; n < 40; n++) begin
            bit          csm, bm, ex;
            logic [3:0]  st;
            int          cl;
            logic [15:0] cd;
            csm = 1'($urandom_range(0, 1));
            bm  = 1'($urandom_range(0, 1));
            st  = 4'($urandom_range(0, 7));
            cl  = $urandom_range(5, 40);
            cd  = 16'($urandom);
            ex  = 1'($urandom_range(0, 1));
            txn(csm, bm, st, cl, cd, ex);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule